// File: doc/BRIEF.md
# Snapshot-Read 64-bit Tick Counter

This block keeps a 64-bit count that advances by one on every cycle in which its tick-enable input is high. Software never reads the running count directly. It reads a held copy, split into a low word and a high word, and refreshes that copy by writing a capture command to the control register. Because both halves come from one capture, a 64-bit value can be read as two 32-bit words without the halves tearing against each other.

A second command in the same control register zeroes the held words and restarts the running count from zero. Both command bits act on the write that carries them and are never stored, so the control register always reads back with those two bits low. The held words can also be written directly, for example to preset a value that software compares against later. Writing them does not alter the running count.

Register offsets on the byte-addressed port: control at 0x0, low word at 0x4, high word at 0x8. In the control word, bit 0 is the clear command and bit 1 is the capture command. Writes happen on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `snapcnt_top`

## Requirements
- R1: After reset the control register, the low word and the high word read 0. A capture issued before any tick returns 0 in both words.
- R2: The running count rises by exactly one at each clock edge where `tick_en` is high, and holds at edges where it is low.
- R3: A write to offset 0x0 with bit 1 set loads the words with the running count as it stood before that edge. Count bits 31:0 go to offset 0x4 and bits 63:32 go to offset 0x8.
- R4: A write to offset 0x0 with bit 0 set zeroes both words and the running count. This holds even when `tick_en` is high in the same cycle.
- R5: When bits 0 and 1 are both set in one control write, the capture is overridden by the clear, and both words read 0 afterwards.
- R6: A control write stores the written value with bits 1:0 forced to 0. Reads of offset 0x0 return that stored value.
- R7: A write to offset 0x4 or 0x8 replaces only that word. It leaves the other word, the control register and the running count unchanged.
- R8: Without a capture or clear, the words keep their value while the running count advances.
- R9: A write to any other offset changes no register. A read of any other offset returns 0.
- R10: The running count carries from the low word into the high word and wraps from all ones to zero. This is checked with a narrowed data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-advance enable, sampled each edge |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |

## Verification
The bench targets the edge where a capture meets a tick. A design that sampled the count after the increment would return a value one too high. It also targets the cycle where clear and tick coincide, where a design giving the increment priority would restart at 1 instead of 0. It checks the capture-plus-clear write, where the wrong ordering leaves a nonzero snapshot. After direct word writes it captures again, to expose a design that lets those writes leak into the running count. It also confirms that the control read-back never shows a command bit. A narrowed instance drives the count across the word boundary and through its wrap, where a broken carry shows up as a stuck high word.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;

    // byte offsets of the register port
    localparam int OFF_CTRL = 0;
    localparam int OFF_LO   = 4;
    localparam int OFF_HI   = 8;

    // command bit positions inside the control word
    localparam int BIT_CLEAR = 0;
    localparam int BIT_LATCH = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LO,
        SEL_HI
    } sel_e;

endpackage

// File: rtl/snapcnt_decode.sv
module snapcnt_decode
    import snapcnt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int NUM_WORDS = 2
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output sel_e              sel,
    output logic              wr_ctrl,
    output logic [NUM_WORDS-1:0] wr_word,
    output logic              do_latch,
    output logic              do_clear
);

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            sel = SEL_CTRL;
        end else if (bus_addr == ADDR_W'(OFF_LO)) begin
            sel = SEL_LO;
        end else if (bus_addr == ADDR_W'(OFF_HI)) begin
            sel = SEL_HI;
        end
    end

    always_comb begin
        wr_ctrl  = bus_we && (sel == SEL_CTRL);
        do_latch = wr_ctrl && bus_wdata[BIT_LATCH];
        do_clear = wr_ctrl && bus_wdata[BIT_CLEAR];
        wr_word  = '0;
        wr_word[0] = bus_we && (sel == SEL_LO);
        wr_word[1] = bus_we && (sel == SEL_HI);
    end

endmodule

// File: rtl/snapcnt_live.sv
module snapcnt_live #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             do_clear,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } live_t;

    live_t live_d, live_q;

    always_comb begin
        live_d = live_q;
        if (do_clear) begin
            live_d.cnt = '0;
        end else if (tick_en) begin
            live_d.cnt = live_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    assign count = live_q.cnt;

endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
    import snapcnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_WORDS = 2,
    localparam int CNT_W = DATA_W * NUM_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [NUM_WORDS-1:0] wr_word,
    input  logic                 do_latch,
    input  logic                 do_clear,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CNT_W-1:0]     live_cnt,
    output logic [DATA_W-1:0]    ctrl,
    output logic [CNT_W-1:0]     snap
);

    localparam logic [DATA_W-1:0] CMD_MASK =
        (DATA_W'(1) << BIT_CLEAR) | (DATA_W'(1) << BIT_LATCH);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  snap;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl = wdata & ~CMD_MASK;
        end
        // capture first, clear second: clear wins when both are set
        if (do_latch) begin
            regs_d.snap = live_cnt;
        end
        if (do_clear) begin
            regs_d.snap = '0;
        end
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (wr_word[w]) begin
                regs_d.snap[w*DATA_W +: DATA_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl = regs_q.ctrl;
    assign snap = regs_q.snap;

endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
    import snapcnt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int NUM_WORDS = 2;
    localparam int CNT_W     = DATA_W * NUM_WORDS;

    sel_e                 sel;
    logic                 wr_ctrl;
    logic [NUM_WORDS-1:0] wr_word;
    logic                 do_latch;
    logic                 do_clear;
    logic [CNT_W-1:0]     live_cnt;
    logic [CNT_W-1:0]     snap_words;
    logic [DATA_W-1:0]    ctrl_word;
    logic [DATA_W-1:0]    word_view [NUM_WORDS];

    snapcnt_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_decode (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sel      (sel),
        .wr_ctrl  (wr_ctrl),
        .wr_word  (wr_word),
        .do_latch (do_latch),
        .do_clear (do_clear)
    );

    snapcnt_live #(
        .CNT_W(CNT_W)
    ) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .do_clear(do_clear),
        .count   (live_cnt)
    );

    snapcnt_regs #(
        .DATA_W(DATA_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_word (wr_word),
        .do_latch(do_latch),
        .do_clear(do_clear),
        .wdata   (bus_wdata),
        .live_cnt(live_cnt),
        .ctrl    (ctrl_word),
        .snap    (snap_words)
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_view
        assign word_view[g] = snap_words[g*DATA_W +: DATA_W];
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: bus_rdata = ctrl_word;
            SEL_LO:   bus_rdata = word_view[0];
            SEL_HI:   bus_rdata = word_view[1];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/snapcnt_chk.sv
module snapcnt_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  live_cnt,
    input logic [CNT_W-1:0]  snap_words,
    input logic [DATA_W-1:0] ctrl_word
);

    logic ctrl_hit;
    logic mapped;
    assign ctrl_hit = bus_we && (bus_addr == ADDR_W'(0));
    assign mapped   = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(4)) ||
                      (bus_addr == ADDR_W'(8));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_hit && bus_wdata[0]) |=>
            live_cnt == $past(live_cnt) + CNT_W'($past(tick_en)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && bus_wdata[1] && !bus_wdata[0]) |=>
            snap_words == $past(live_cnt));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && bus_wdata[0]) |=> (snap_words == '0) && (live_cnt == '0));

    assert_ctrl_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> ctrl_word == ($past(bus_wdata) & ~DATA_W'(3)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(snap_words) && $stable(ctrl_word));

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> $stable(snap_words) && $stable(ctrl_word));

endmodule

bind snapcnt_top snapcnt_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .live_cnt  (live_cnt),
    .snap_words(snap_words),
    .ctrl_word (ctrl_word)
);

// File: tb/sim_snapcnt_top.sv
module sim_snapcnt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    logic        n_tick = 1'b0;
    logic        n_we = 1'b0;
    logic [3:0]  n_addr = '0;
    logic [7:0]  n_wdata = '0;
    logic [7:0]  n_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] m_cnt;
    logic [63:0] m_snap;
    logic [31:0] m_ctrl;

    always #2 clk = ~clk;

    snapcnt_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    snapcnt_top #(.ADDR_W(4), .DATA_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(n_tick), .bus_we(n_we),
        .bus_addr(n_addr), .bus_wdata(n_wdata), .bus_rdata(n_rdata)
    );

    function automatic logic [31:0] f_ctrl_rb(input logic [31:0] w);
        return w & ~32'h3;
    endfunction

    function automatic logic [31:0] f_read(input logic [3:0] a);
        case (a)
            4'h0:    return m_ctrl;
            4'h4:    return m_snap[31:0];
            4'h8:    return m_snap[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock cycle on u0 with model update
    task automatic cyc(input logic t, input logic we, input logic [3:0] a, input logic [31:0] d);
        logic clr;
        @(negedge clk);
        tick_en = t; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        clr = we && a == 4'h0 && d[0];
        if (we && a == 4'h0) begin
            m_ctrl = f_ctrl_rb(d);
            if (d[1]) m_snap = m_cnt;
            if (d[0]) m_snap = '0;
        end else if (we && a == 4'h4) begin
            m_snap[31:0] = d;
        end else if (we && a == 4'h8) begin
            m_snap[63:32] = d;
        end
        m_cnt = clr ? 64'h0 : m_cnt + 64'(t);
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0; bus_addr = a;
        #1 check(req, bus_rdata, f_read(a));
    endtask

    task automatic rd_all(input string req);
        rd(req, 4'h0); rd(req, 4'h4); rd(req, 4'h8);
    endtask

    task automatic n_run(input int n);
        @(negedge clk);
        n_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        n_tick = 1'b0; n_we = 1'b1; n_addr = 4'h0; n_wdata = 8'h02;
        @(posedge clk);
        @(negedge clk);
        n_we = 1'b0;
    endtask

    task automatic n_rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        n_addr = a;
        #1 check(req, {24'h0, n_rdata}, {24'h0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C41));
        m_cnt = '0; m_snap = '0; m_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_all("R1");
        cyc(1'b0, 1'b1, 4'h0, 32'h2);
        rd_all("R1");

        // R2/R3 ticks with gaps, capture with tick high on the same edge
        for (int i = 0; i < 12; i++) cyc(i % 3 != 0, 1'b0, 4'h0, 0);
        cyc(1'b1, 1'b1, 4'h0, 32'h2);
        rd("R3", 4'h4); rd("R2", 4'h8);
        check("R2", m_snap[31:0], 32'd8);

        // R8 hold while counting
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 4'h0, 0);
        rd_all("R8");

        // R4 clear with tick in same cycle
        cyc(1'b1, 1'b1, 4'h0, 32'h1);
        rd_all("R4");
        cyc(1'b0, 1'b1, 4'h0, 32'h2);
        rd("R4", 4'h4);

        // R5 both bits
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 4'h0, 0);
        cyc(1'b1, 1'b1, 4'h0, 32'h3);
        rd_all("R5");

        // R6 read-back masks command bits
        cyc(1'b0, 1'b1, 4'h0, 32'hFFFF_FFFF);
        rd("R6", 4'h0);
        check("R6", bus_rdata, 32'hFFFF_FFFC);

        // R7 direct word writes leave count alone
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 4'h0, 0);
        cyc(1'b0, 1'b1, 4'h8, 32'hDEAD_BEEF);
        rd_all("R7");
        cyc(1'b0, 1'b1, 4'h4, 32'h1234_5678);
        rd_all("R7");
        cyc(1'b0, 1'b1, 4'h0, 32'h2);
        rd_all("R7");

        // R9 unmapped offsets
        cyc(1'b0, 1'b1, 4'hC, 32'hFFFF_FFFF);
        rd_all("R9");
        rd("R9", 4'hC);
        rd("R9", 4'h2);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic t;
            op = $urandom % 8;
            t  = 1'($urandom % 2);
            case (op)
                0, 1:    cyc(t, 1'b0, 4'h0, 0);
                2:       cyc(t, 1'b1, 4'h0, ($urandom & ~32'h3) | 32'h2);
                3:       cyc(t, 1'b1, 4'h0, $urandom);
                4:       cyc(t, 1'b1, 4'h4, $urandom);
                5:       cyc(t, 1'b1, 4'h8, $urandom);
                6:       cyc(t, 1'b1, 4'(($urandom % 4) * 4 + 12), $urandom);
                default: for (int k = 0; k < 1 + $urandom % 6; k++) cyc(1'b1, 1'b0, 4'h0, 0);
            endcase
            rd_all("R3");
        end

        // R10 carry and wrap on the narrow instance
        n_run(255);
        n_rd("R10", 4'h4, 8'hFF); n_rd("R10", 4'h8, 8'h00);
        n_run(1);
        n_rd("R10", 4'h4, 8'h00); n_rd("R10", 4'h8, 8'h01);
        n_run(65279);
        n_rd("R10", 4'h4, 8'hFF); n_rd("R10", 4'h8, 8'hFF);
        n_run(1);
        n_rd("R10", 4'h4, 8'h00); n_rd("R10", 4'h8, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule